// File: doc/BRIEF.md
# Short-Cycle Successive Approximation Controller

This block is the digital heart of a successive approximation converter. After a convert command it resolves the result one bit per clock, starting at the most significant bit. Each cycle it drives a trial word to an external DAC and reads back a one-bit comparator verdict. It keeps the bit under trial when the comparator says the analog input is at or above the DAC level, and clears it otherwise. A two-bit length select can stop the conversion after 14, 13 or 12 decisions instead of all 16. The undecided low bits then stay at zero.

The convert command works like a reset. While it is high the controller is held cleared. A high pulse of at least `MIN_HIGH` clock edges followed by a low level starts a conversion. Raising the command during a conversion abandons that conversion. The result comes out on a parallel word in which every bit is inverted (0 means a true 1), with an option to turn it into two's-complement form by leaving the top bit uninverted. The same inverted bits also leave as an NRZ serial stream, most significant bit first. The stream comes with a gated bit clock whose rising edges fall in the middle of each serial bit. A status flag is high while bits are being decided.

Top module: `sar_sc_ctrl`

## Requirements
- R1: While `conv_cmd` is high the block is held clear: `busy`=0, `dac_word`=0, `par_n` all ones when `tc_mode`=0, `ser_n`=1, `sclk`=0.
- R2: A conversion starts at the first clock edge that samples `conv_cmd` low after it was sampled high on at least `MIN_HIGH` (default 5) consecutive edges. A shorter high pulse starts nothing: `busy` stays 0.
- R3: While `busy` is high, `dac_word` equals the bits decided so far plus one trial bit, moving from bit 15 down one position per clock. At each edge the trial bit takes the value of `cmp_hi` (1 keeps it).
- R4: `len_sel` chooses the number of decisions: 00→16, 01→14, 10→13, 11→12. `busy` is high for exactly that many clock cycles, and the undecided low bits stay 0, so they read 1 on `par_n`.
- R5: `par_n` is the bitwise inverse of the result. With `tc_mode`=1, bit 15 of `par_n` carries the true (uninverted) top bit instead.
- R6: In the cycle after each decision edge, `ser_n` carries the inverse of the bit just decided. It is 1 in every other cycle, so exactly N bits leave, most significant first.
- R7: `sclk` is high during the low phase of the clock in every cycle in which `ser_n` carries a bit, and low at all other times.
- R8: Raising `conv_cmd` during a conversion ends it at the next edge: `busy` drops and the result clears to zero.
- R9: After a conversion, `par_n` keeps the result until `conv_cmd` next goes high.
- R10: `rst_n` low clears the block at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_cmd | input | 1 | Convert command; high clears, falling edge starts |
| len_sel | input | 2 | Number of decisions (00=16, 01=14, 10=13, 11=12) |
| tc_mode | input | 1 | 1 leaves the top parallel bit uninverted |
| cmp_hi | input | 1 | Comparator: 1 when input ≥ DAC level |
| dac_word | output | 16 | Trial word for the external DAC |
| par_n | output | 16 | Inverted parallel result |
| ser_n | output | 1 | Inverted NRZ serial result, MSB first |
| sclk | output | 1 | Gated bit clock for the serial stream |
| busy | output | 1 | High while bits are being decided |

## Verification
The hardest cases to reach are command edges that land at the edge of what the block accepts: a high pulse exactly one edge shorter than the minimum, one exactly at the minimum, and a command raised partway through the bit sequence. The bench reaches them by holding `conv_cmd` high for a counted number of clock edges, and by raising it a set number of cycles into a running conversion. The bench also pulls `rst_n` low between two edges and checks the clear before the next edge arrives. Its ideal comparator is a comparison of the port `dac_word` against a stimulus code, so every length setting must reproduce that code truncated to its top N bits.

// File: rtl/sar_sc_pkg.sv
package sar_sc_pkg;

  typedef enum logic [1:0] {
    LEN_FULL = 2'b00,
    LEN_DROP2 = 2'b01,
    LEN_DROP3 = 2'b10,
    LEN_DROP4 = 2'b11
  } len_sel_e;

  // index of the last bit decided for a given length setting
  function automatic int unsigned stop_index(input logic [1:0] sel);
    case (len_sel_e'(sel))
      LEN_DROP2: return 2;
      LEN_DROP3: return 3;
      LEN_DROP4: return 4;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/sar_cmd_qual.sv
module sar_cmd_qual #(
  parameter int unsigned MIN_HIGH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  output logic start
);
  localparam int unsigned CW = $clog2(MIN_HIGH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_HIGH);

  logic          cmd_q, cmd_d;
  logic [CW-1:0] hi_cnt_q, hi_cnt_d;

  always_comb begin
    cmd_d = cmd;
    if (cmd) hi_cnt_d = (hi_cnt_q == CNT_MAX) ? hi_cnt_q : hi_cnt_q + 1'b1;
    else     hi_cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      cmd_q    <= cmd_d;
      hi_cnt_q <= hi_cnt_d;
    end
  end

  assign start = cmd_q & ~cmd & (hi_cnt_q == CNT_MAX);
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int unsigned W = 16,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic          cmp,
  input  logic [PW-1:0] stop_idx,
  output logic          busy,
  output logic          dec_en,
  output logic          dec_bit,
  output logic [W-1:0]  result,
  output logic [W-1:0]  trial
);
  localparam logic [PW-1:0] TOP = PW'(W - 1);

  logic          busy_q, busy_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic [W-1:0]  res_q, res_d;
  logic          upd;

  assign dec_en  = busy_q & ~clr;
  assign dec_bit = cmp;
  assign upd     = clr | start | busy_q;

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    res_d  = res_q;
    if (clr) begin
      busy_d = 1'b0;
      ptr_d  = TOP;
      res_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      ptr_d  = TOP;
      res_d  = '0;
    end else if (busy_q) begin
      res_d[ptr_q] = cmp;
      if (ptr_q == stop_idx) busy_d = 1'b0;
      else                   ptr_d  = ptr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= TOP;
      res_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      res_q  <= res_d;
    end
  end

  assign busy   = busy_q;
  assign result = res_q;
  assign trial  = busy_q ? (res_q | (W'(1) << ptr_q)) : res_q;

  // R1: a high command leaves the core idle and empty
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy_q && res_q == '0));

  // R2: every conversion begins empty with the top bit on trial
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (res_q == '0 && ptr_q == TOP));

  // R3: the trial position walks down by one per clock
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !clr && ptr_q != stop_idx) |=> (busy_q && ptr_q == $past(ptr_q) - 1'b1));

  // R3: the decided bit follows the comparator
  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !clr) |=> (res_q[$past(ptr_q)] == $past(cmp)));

  // R4: bits at and below the trial position are still zero
  assert_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((res_q << (TOP - ptr_q)) == '0));
endmodule

// File: rtl/sar_ser_out.sv
module sar_ser_out (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dec_en,
  input  logic dec_bit,
  output logic ser_n,
  output logic sclk
);
  logic vld_q, vld_d;
  logic bit_q, bit_d;
  logic upd;

  assign upd = clr | dec_en | vld_q;

  always_comb begin
    vld_d = vld_q;
    bit_d = bit_q;
    if (clr) begin
      vld_d = 1'b0;
      bit_d = 1'b0;
    end else begin
      vld_d = dec_en;
      if (dec_en) bit_d = dec_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else if (upd) begin
      vld_q <= vld_d;
      bit_q <= bit_d;
    end
  end

  assign ser_n = vld_q ? ~bit_q : 1'b1;
  assign sclk  = vld_q & ~clk;
endmodule

// File: rtl/sar_sc_ctrl.sv
module sar_sc_ctrl #(
  parameter int unsigned W        = 16,
  parameter int unsigned MIN_HIGH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_cmd,
  input  logic [1:0]   len_sel,
  input  logic         tc_mode,
  input  logic         cmp_hi,
  output logic [W-1:0] dac_word,
  output logic [W-1:0] par_n,
  output logic         ser_n,
  output logic         sclk,
  output logic         busy
);
  import sar_sc_pkg::*;

  localparam int unsigned PW = $clog2(W);

  logic          srst_n;
  logic          start;
  logic          dec_en;
  logic          dec_bit;
  logic [W-1:0]  result;
  logic [PW-1:0] stop_idx;

  assign stop_idx = PW'(stop_index(len_sel));

  sar_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sar_cmd_qual #(.MIN_HIGH(MIN_HIGH)) u_cmd (
    .clk   (clk),
    .rst_n (srst_n),
    .cmd   (conv_cmd),
    .start (start)
  );

  sar_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (conv_cmd),
    .start    (start),
    .cmp      (cmp_hi),
    .stop_idx (stop_idx),
    .busy     (busy),
    .dec_en   (dec_en),
    .dec_bit  (dec_bit),
    .result   (result),
    .trial    (dac_word)
  );

  sar_ser_out u_ser (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (conv_cmd),
    .dec_en  (dec_en),
    .dec_bit (dec_bit),
    .ser_n   (ser_n),
    .sclk    (sclk)
  );

  assign par_n = {~result[W-1] ^ tc_mode, ~result[W-2:0]};

  // R8: a command raised mid-conversion abandons it
  assert_abort_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && conv_cmd) |=> (!busy && result == '0));

  // R6: the final serial bit matches the lowest decided parallel bit
  assert_lastser_R6: assert property (@(posedge clk) disable iff (!srst_n)
    ($fell(busy) && !conv_cmd) |-> (ser_n == ~result[stop_idx]));
endmodule

// File: tb/sim_sar_sc_ctrl.sv
module sim_sar_sc_ctrl;
  localparam int MINH = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_cmd;
  logic [1:0]  len_sel;
  logic        tc_mode;
  logic        cmp_hi;
  logic [15:0] dac_word, par_n;
  logic        ser_n, sclk, busy;
  logic [15:0] vin;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sar_sc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .conv_cmd(conv_cmd), .len_sel(len_sel),
    .tc_mode(tc_mode), .cmp_hi(cmp_hi), .dac_word(dac_word), .par_n(par_n),
    .ser_n(ser_n), .sclk(sclk), .busy(busy)
  );

  // ideal comparator against the stimulus code
  assign cmp_hi = (dac_word <= vin);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_res = 0, m_ptr = 15, m_hicnt = 0, m_stop;
  bit m_busy = 0, m_svld = 0, m_sbit = 0, m_cmdp = 0;

  function automatic int nbits(input logic [1:0] s);
    case (s) 2'b01: return 14; 2'b10: return 13; 2'b11: return 12; default: return 16; endcase
  endfunction

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_res = 0; m_ptr = 15; m_busy = 0; m_svld = 0; m_sbit = 0; m_cmdp = 0; m_hicnt = 0;
    end else if (conv_cmd) begin
      m_res = 0; m_ptr = 15; m_busy = 0; m_svld = 0; m_sbit = 0;
      m_hicnt = (m_hicnt >= MINH) ? MINH : m_hicnt + 1;
      m_cmdp = 1;
    end else begin
      if (m_cmdp && m_hicnt >= MINH) begin
        m_busy = 1; m_ptr = 15; m_res = 0; m_svld = 0;
      end else if (m_busy) begin
        int tw;
        bit b;
        tw = m_res | (1 << m_ptr);
        b = (tw <= int'(vin));
        if (b) m_res = m_res | (1 << m_ptr);
        m_sbit = b; m_svld = 1;
        m_stop = 16 - nbits(len_sel);
        if (m_ptr == m_stop) m_busy = 0; else m_ptr = m_ptr - 1;
      end else begin
        m_svld = 0;
      end
      m_hicnt = 0;
      m_cmdp = 0;
    end
    #3;
    begin
      int e_dac, e_par;
      e_dac = m_busy ? (m_res | (1 << m_ptr)) : m_res;
      e_par = (~m_res & 16'hFFFF) ^ (int'(tc_mode) << 15);
      chk(busy == m_busy, "R4 busy", int'(busy), int'(m_busy));
      chk(dac_word == 16'(e_dac), "R3 dac_word", int'(dac_word), e_dac);
      chk(par_n == 16'(e_par), "R5 par_n", int'(par_n), e_par);
      chk(ser_n == (m_svld ? ~m_sbit : 1'b1), "R6 ser_n", int'(ser_n), int'(m_svld ? ~m_sbit : 1'b1));
      chk(sclk == 1'b0, "R7 sclk high phase", int'(sclk), 0);
    end
  end

  always begin
    @(negedge clk);
    #2;
    chk(sclk == m_svld, "R7 sclk low phase", int'(sclk), int'(m_svld));
  end

  // serial capture on the bit clock
  logic [15:0] ser_bits = '0;
  int ser_cnt = 0;
  always @(posedge sclk) begin
    ser_bits = {ser_bits[14:0], ser_n};
    ser_cnt++;
  end

  task automatic run_conv(input logic [15:0] v, input logic [1:0] sel, input bit tc, input int hold);
    int n, bcnt, exp_res, exp_par, exp_ser;
    n = nbits(sel);
    @(negedge clk);
    vin = v; len_sel = sel; tc_mode = tc; conv_cmd = 1'b1;
    repeat (hold) @(negedge clk);
    ser_cnt = 0;
    conv_cmd = 1'b0;
    bcnt = 0;
    repeat (n + 4) begin
      @(posedge clk); #4;
      if (busy) bcnt++;
    end
    if (hold >= MINH) begin
      exp_res = int'(v) & ~((1 << (16 - n)) - 1) & 16'hFFFF;
      exp_par = (~exp_res & 16'hFFFF) ^ (int'(tc) << 15);
      exp_ser = (~int'(v) >> (16 - n)) & ((1 << n) - 1);
      chk(bcnt == n, "R4 busy cycles", bcnt, n);
      chk(par_n == 16'(exp_par), "R5 result", int'(par_n), exp_par);
      chk(ser_cnt == n, "R6 serial bit count", ser_cnt, n);
      chk((int'(ser_bits) & ((1 << n) - 1)) == exp_ser, "R6 serial stream",
          int'(ser_bits) & ((1 << n) - 1), exp_ser);
      repeat (8) @(negedge clk);
      chk(par_n == 16'(exp_par), "R9 result held", int'(par_n), exp_par);
    end else begin
      chk(bcnt == 0, "R2 short pulse ignored", bcnt, 0);
      chk(par_n == 16'hFFFF, "R2 short pulse result", int'(par_n), 16'hFFFF);
    end
  endtask

  initial begin
    rst_n = 1'b0; conv_cmd = 1'b1; len_sel = 2'b00; tc_mode = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #2;
    chk(busy == 1'b0, "R1 idle busy", int'(busy), 0);
    chk(par_n == 16'hFFFF, "R1 idle par_n", int'(par_n), 16'hFFFF);
    chk(dac_word == 16'h0000, "R1 idle dac_word", int'(dac_word), 0);
    chk(ser_n == 1'b1, "R1 idle ser_n", int'(ser_n), 1);

    run_conv(16'h9896, 2'b00, 1'b0, 6);
    run_conv(16'h9896, 2'b00, 1'b1, 6);
    run_conv(16'h0000, 2'b00, 1'b0, 6);
    run_conv(16'hFFFF, 2'b00, 1'b1, 6);
    run_conv(16'hFFFF, 2'b01, 1'b0, 6);
    run_conv(16'h8001, 2'b10, 1'b0, 6);
    run_conv(16'h7FFF, 2'b11, 1'b1, 6);
    run_conv(16'h5A5A, 2'b01, 1'b0, 6);
    run_conv(16'h1234, 2'b00, 1'b0, MINH - 1);   // R2 one edge short
    run_conv(16'h1234, 2'b00, 1'b0, MINH);       // R2 exactly minimum

    // R8 abort mid-conversion
    @(negedge clk);
    vin = 16'hC3C3; len_sel = 2'b00; tc_mode = 1'b0; conv_cmd = 1'b1;
    repeat (6) @(negedge clk);
    conv_cmd = 1'b0;
    repeat (6) @(negedge clk);
    conv_cmd = 1'b1;
    @(posedge clk); #4;
    chk(busy == 1'b0, "R8 abort busy", int'(busy), 0);
    chk(par_n == 16'hFFFF, "R8 abort result", int'(par_n), 16'hFFFF);
    run_conv(16'hC3C3, 2'b00, 1'b0, 6);

    // R10 asynchronous reset between edges
    @(negedge clk);
    vin = 16'hA5A5; conv_cmd = 1'b1;
    repeat (6) @(negedge clk);
    conv_cmd = 1'b0;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(busy == 1'b0, "R10 async clear busy", int'(busy), 0);
    chk(par_n == 16'hFFFF, "R10 async clear par_n", int'(par_n), 16'hFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_conv(16'hA5A5, 2'b11, 1'b0, 6);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule